// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns a 32 kHz master sample tick into one sample-enable strobe per playback channel. Each channel has its own 3-bit rate code, so three channels playing together can each run at a different audio rate. The code chooses how many master ticks pass between strobes. The rates are 32, 16, about 12.8, 8, 6.4, about 5.3 and 4 kHz. The 12.8 kHz rate needs a divide ratio of 2.5. The block gets this ratio by alternating intervals of 2 and 3 master ticks, so the long-run rate is exact.

A channel is restarted with a one-cycle pulse when a new prompt begins. The restart clears the channel's tick count and its alternation phase. The first strobe then comes one full period later. A downstream decoder uses the strobe to decide when to take its next sample.

Top module: `rate_strobe_gen`

## Requirements
- R1: During and right after synchronous active-high reset, every strobe output is 0.
- R2: Each rate code sets the number of master ticks per strobe: code 0 gives 8, code 1 gives 6, code 2 gives 5, code 3 gives 4, code 5 gives 2 and code 6 gives 1.
- R3: Code 4 alternates intervals of 2 and 3 master ticks, starting with 2 after a restart. The strobes fall on ticks 2, 5, 7, 10 and so on, which is 2 strobes per 5 ticks.
- R4: Code 7 is invalid. It never produces a strobe and keeps that channel's tick count at zero.
- R5: A strobe is a single-clock pulse. It appears in the clock cycle after the master tick that completes a period, and never in any other cycle.
- R6: A restart clears the channel's count and phase. A master tick in the same cycle as the restart is not counted. The first strobe follows the N-th later tick, where N is the period.
- R7: A restart affects only its own channel. The other channels keep counting and keep their strobe timing.
- R8: When a channel's code changes while it is counting, the accumulated count is kept. If that count already meets or exceeds the new period, the channel strobes on its next master tick.
- R9: Only master ticks advance a channel. Master ticks may arrive on consecutive clocks or with any gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Master 32 kHz sample tick, one clock wide |
| rate_code | input | NUM_CH*3 | Per-channel rate code; channel c uses bits [3c+2:3c] |
| restart | input | NUM_CH | Per-channel restart pulse |
| strobe | output | NUM_CH | Per-channel sample-enable strobe, registered |

## Verification
A wrong count or a wrong phase bit inside one channel shows up as a strobe on the wrong master tick. With code 4 it also shows up as a 3-then-2 interval order instead of 2-then-3. Either error is visible at the strobe port within one period, which is at most 8 master ticks after the fault. A restart that clears too little, or clears the wrong channel, moves the very next strobe of the affected channel. Strobe totals over long tick runs show any drift in the average ratio.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_DIV  = 8;
  localparam int CNT_W    = $clog2(MAX_DIV);
  localparam int PER_W    = CNT_W + 1;

  typedef logic [CODE_W-1:0] rate_code_t;

  localparam rate_code_t CODE_DIV8  = 3'd0;
  localparam rate_code_t CODE_DIV6  = 3'd1;
  localparam rate_code_t CODE_DIV5  = 3'd2;
  localparam rate_code_t CODE_DIV4  = 3'd3;
  localparam rate_code_t CODE_HALF  = 3'd4;
  localparam rate_code_t CODE_DIV2  = 3'd5;
  localparam rate_code_t CODE_DIV1  = 3'd6;
  localparam rate_code_t CODE_OFF   = 3'd7;
endpackage

// File: rtl/rsg_period_decode.sv
module rsg_period_decode
  import rsg_pkg::*;
(
  input  rate_code_t       code,
  input  logic             phase,
  output logic [PER_W-1:0] period,
  output logic             valid
);
  always_comb begin
    valid  = 1'b1;
    period = PER_W'(1);
    unique case (code)
      CODE_DIV8: period = PER_W'(8);
      CODE_DIV6: period = PER_W'(6);
      CODE_DIV5: period = PER_W'(5);
      CODE_DIV4: period = PER_W'(4);
      CODE_HALF: period = phase ? PER_W'(3) : PER_W'(2);
      CODE_DIV2: period = PER_W'(2);
      CODE_DIV1: period = PER_W'(1);
      default: begin
        valid  = 1'b0;
        period = PER_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/rsg_channel.sv
module rsg_channel
  import rsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  rate_code_t code,
  output logic       strobe
);
  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic [PER_W-1:0] period;
  logic             valid;
  logic [PER_W-1:0] cnt_next;
  logic             hit;

  rsg_period_decode u_dec (
    .code  (code),
    .phase (phase),
    .period(period),
    .valid (valid)
  );

  assign cnt_next = {1'b0, cnt} + PER_W'(1);
  assign hit      = tick && valid && (cnt_next >= period);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt    <= '0;
      phase  <= 1'b0;
      strobe <= 1'b0;
    end else begin
      strobe <= hit;
      if (!valid) begin
        cnt <= '0;
      end else if (tick) begin
        if (hit) begin
          cnt <= '0;
          if (code == CODE_HALF) phase <= ~phase;
        end else begin
          cnt <= cnt_next[CNT_W-1:0];
        end
      end
    end
  end

  // R5: a strobe only ever follows an accepted master tick
  a_r5_strobe_follows_tick: assert property (@(posedge clk) disable iff (rst)
    strobe |-> ($past(tick) && !$past(restart)));

  // R4: the invalid code never yields a strobe
  a_r4_invalid_silent: assert property (@(posedge clk) disable iff (rst)
    strobe |-> ($past(code) != CODE_OFF));

  // R2: divide-by-one strobes on every accepted tick
  a_r2_unit_period: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && code == CODE_DIV1) |=> strobe);

  // R6: a restart suppresses the strobe in the following cycle
  a_r6_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |=> !strobe);

  // R9: without a tick the count does not move
  a_r9_count_holds: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart && code != CODE_OFF) |=> $stable(cnt));
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rsg_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_in,
  input  logic [NUM_CH*CODE_W-1:0] rate_code,
  input  logic [NUM_CH-1:0]        restart,
  output logic [NUM_CH-1:0]        strobe
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rsg_channel u_ch (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_in),
      .restart(restart[c]),
      .code   (rate_code[c*CODE_W +: CODE_W]),
      .strobe (strobe[c])
    );
  end

  // R1: strobes are low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (strobe == '0));

  // R5: no strobe can appear unless a tick came the cycle before
  a_r5_top_tick: assert property (@(posedge clk) disable iff (rst)
    (strobe != '0) |-> $past(tick_in));
endmodule

// File: tb/tb_rate_strobe_gen.sv
`timescale 1ns/1ps
module tb_rate_strobe_gen;
  localparam int NCH = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [NCH*3-1:0] codes = '0;
  logic [NCH-1:0] rs = '0;
  logic [NCH-1:0] strobe;
  int n_run = 0;
  int n_fail = 0;
  int cnt [NCH];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rate_strobe_gen #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .tick_in(tick), .rate_code(codes),
    .restart(rs), .strobe(strobe)
  );

  always @(negedge clk)
    if (!rst) for (int c = 0; c < NCH; c++) cnt[c] += int'(strobe[c]);

  // c0 c1 c2 ticks gap exp0 exp1 exp2
  typedef int vec_t [8];
  localparam vec_t VECS [8] = '{
    '{0, 1, 2, 40, 0, 5, 6, 8},
    '{3, 4, 5, 40, 0, 10, 16, 20},
    '{6, 7, 0, 40, 2, 40, 0, 5},
    '{4, 4, 4, 12, 1, 5, 5, 5},
    '{2, 6, 1, 17, 3, 3, 17, 2},
    '{5, 3, 4, 7, 0, 3, 1, 3},
    '{7, 7, 7, 20, 0, 0, 0, 0},
    '{1, 0, 3, 48, 0, 8, 6, 12}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_code(input int c, input int v);
    codes[c*3 +: 3] = 3'(v);
  endtask

  task automatic do_restart(input logic [NCH-1:0] m);
    @(negedge clk) rs = m;
    @(negedge clk) rs = '0;
  endtask

  // one isolated tick; returns strobe as seen the cycle after
  task automatic one_tick(output logic [NCH-1:0] s);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    s = strobe;
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      if (gap > 0) begin
        @(negedge clk) tick = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] s;
    logic [NCH-1:0] s2;
    repeat (4) @(negedge clk);
    chk("R1 strobe during reset", int'(strobe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobe after reset", int'(strobe), 0);

    // R2 R3 R4 R9: table of rate patterns
    foreach (VECS[k]) begin
      for (int c = 0; c < NCH; c++) set_code(c, VECS[k][c]);
      do_restart('1);
      for (int c = 0; c < NCH; c++) cnt[c] = 0;
      run_ticks(VECS[k][3], VECS[k][4]);
      for (int c = 0; c < NCH; c++)
        chk($sformatf("R2/R3/R4/R9 vec%0d ch%0d count", k, c), cnt[c], VECS[k][5+c]);
    end

    // R3 R5: code 4 strobe positions 2,5,7,10 and single-cycle pulse
    for (int c = 0; c < NCH; c++) set_code(c, 4);
    do_restart('1);
    for (int t = 1; t <= 10; t++) begin
      one_tick(s);
      chk($sformatf("R3 half-rate tick %0d", t), int'(s[0]),
          (t == 2 || t == 5 || t == 7 || t == 10) ? 1 : 0);
      @(negedge clk) s2 = strobe;
      chk($sformatf("R5 pulse width tick %0d", t), int'(s2[0]), 0);
    end

    // R6: restart with coincident tick is not counted; first strobe at 4th tick
    set_code(0, 3);
    do_restart('1);
    for (int t = 0; t < 3; t++) one_tick(s);
    @(negedge clk) begin rs = 3'b001; tick = 1'b1; end
    @(negedge clk) begin rs = '0; tick = 1'b0; end
    chk("R6 no strobe on restart tick", int'(strobe[0]), 0);
    for (int t = 1; t <= 4; t++) begin
      one_tick(s);
      chk($sformatf("R6 after restart tick %0d", t), int'(s[0]), t == 4 ? 1 : 0);
    end

    // R8: count 6 under divide-by-8, switch to divide-by-4 -> next tick strobes
    set_code(0, 0);
    do_restart('1);
    for (int t = 0; t < 6; t++) one_tick(s);
    chk("R8 no strobe before switch", int'(s[0]), 0);
    set_code(0, 3);
    one_tick(s);
    chk("R8 strobe after code change", int'(s[0]), 1);

    // R4: code 7 keeps count at zero; switch to divide-by-2 needs two ticks
    set_code(1, 7);
    do_restart('1);
    for (int t = 0; t < 5; t++) begin
      one_tick(s);
      chk("R4 invalid code silent", int'(s[1]), 0);
    end
    set_code(1, 5);
    one_tick(s);
    chk("R4 count held at zero (1st tick)", int'(s[1]), 0);
    one_tick(s);
    chk("R4 count held at zero (2nd tick)", int'(s[1]), 1);

    // R7: restart channel 1 only; channel 0 keeps its count
    set_code(0, 3); set_code(1, 3); set_code(2, 3);
    do_restart('1);
    one_tick(s); one_tick(s);
    do_restart(3'b010);
    one_tick(s); one_tick(s);
    chk("R7 untouched ch0 strobes", int'(s[0]), 1);
    chk("R7 untouched ch2 strobes", int'(s[2]), 1);
    chk("R7 restarted ch1 quiet", int'(s[1]), 0);
    one_tick(s); one_tick(s);
    chk("R7 restarted ch1 strobes later", int'(s[1]), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule